// File: doc/BRIEF.md
# Dual-Compare Waveform Timer

This block is a 16-bit up-counting timer with two compare channels. Each channel has its own compare register. Software writes a compare register through a small word-wide register port. While the timer is stopped, a write takes effect at once. While the timer runs, the write is held in a buffer. The buffer moves into the active register at a point set by the mode: the overflow tick in free-run mode, or the compare-1 match tick in clear mode. A compare-0 match, a compare-1 match and a counter overflow each raise their own single-cycle interrupt pulse. The pulse comes in the same cycle as the count tick that causes it.

The count source is chosen from four options: every clock, every 8th clock, every 32nd clock, or an external tick input. The count advances only while the run bit is set. Clearing the run bit forces the counter, the prescaler phase and the waveform level back to zero.

A single waveform level is updated by a programmable action on each match. Six outputs carry this level. Each output is gated by its own enable bit and its own port-data input. Each group of three outputs can be inverted.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the count reads 0, all three interrupt outputs are low, every `wave_o` bit is 0, and every register reads 0.
- R2: While running, the count rises by exactly one on each count tick and holds between ticks. A write to the count address (4) changes nothing.
- R3: While the run bit (control bit 0) is 0, the count reads 0, the waveform level is 0 and the prescaler phase restarts. Counting resumes from 0 when the run bit is set again.
- R4: Control bits [3:2] select the count tick. 0 gives every clock. 1 gives every 8th clock since the run bit was set. 2 gives every 32nd clock since the run bit was set. 3 gives every clock in which `alt_tick_i` is 1.
- R5: `irq_cmp0_o` is 1 exactly in a tick cycle whose current count equals the active compare-0 value.
- R6: `irq_cmp1_o` is 1 exactly in a tick cycle whose current count equals the active compare-1 value. With control bit 1 (clear mode) set, that tick sends the count to 0 instead of count+1.
- R7: `irq_ovf_o` is 1 exactly in a tick cycle whose count is 0xFFFF. The count then wraps to 0.
- R8: While stopped, a write to address 2 (compare 0) or address 3 (compare 1) updates the active compare value on the next clock.
- R9: While running, compare writes go only to a buffer. The buffer is copied to the active value on an overflow tick when control bit 1 is 0, or on a compare-1 match tick when control bit 1 is 1. A write in the copy cycle lands in the buffer only.
- R10: Control bits [5:4] give the level action on a compare-0 match and bits [7:6] the action on a compare-1 match. The encoding is 0 = hold, 1 = drive 0, 2 = drive 1, 3 = toggle. When both match on one tick, only the compare-1 action applies.
- R11: `wave_o[i]` = `port_data_i[i]` AND enable bit i AND (level XOR invert bit). The enable bits are address 1 bits [5:0]. Outputs 0..2 use control bit 8 as their invert bit and outputs 3..5 use control bit 9.
- R12: `rdata_o` follows `addr_i` without a clock. Address 0 returns control bits [9:0] and address 1 the enables. Addresses 2 and 3 return the active compare values, address 4 returns the count, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alt_tick_i | input | 1 | Alternate count tick, used when source select is 3 |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| port_data_i | input | 6 | Per-output gate; 0 forces the output low |
| wave_o | output | 6 | Waveform outputs |
| irq_cmp0_o | output | 1 | Compare-0 match pulse |
| irq_cmp1_o | output | 1 | Compare-1 match pulse |
| irq_ovf_o | output | 1 | Counter overflow pulse |

## Verification
Both compare channels can match on the same tick. Three things then have to resolve together: the two level actions, the clear-mode reset and the buffer transfer. Directed sessions set both compare values equal with conflicting actions. Random sessions keep compare values small, so that coincidences and mid-run writes landing on transfer ticks happen often. A cycle model in the bench predicts both pulses, the resulting level on all six outputs and the transferred compare value, and the bench compares these against the ports every cycle.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_OEN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP1  = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } lvl_act_e;

  typedef enum logic [1:0] {
    SRC_DIV1  = 2'd0,
    SRC_DIVA  = 2'd1,
    SRC_DIVB  = 2'd2,
    SRC_ALT   = 2'd3
  } src_e;

  typedef struct packed {
    logic [1:0] inv;
    lvl_act_e   act1;
    lvl_act_e   act0;
    src_e       src;
    logic       clr;
    logic       run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  function automatic logic apply_act(lvl_act_e a, logic cur);
    case (a)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler
  import dct_pkg::*;
#(
  parameter int unsigned DIV_A = 8,
  parameter int unsigned DIV_B = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  src_e src_i,
  input  logic alt_tick_i,
  output logic tick_o
);

  localparam int unsigned PW = $clog2(DIV_B);
  localparam logic [PW-1:0] MASK_A = PW'(DIV_A - 1);
  localparam logic [PW-1:0] MASK_B = PW'(DIV_B - 1);

  logic [PW-1:0] psc_q;
  logic          src_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psc_q <= '0;
    else if (!run_i) psc_q <= '0;
    else             psc_q <= psc_q + PW'(1);
  end

  always_comb begin
    case (src_i)
      SRC_DIV1: src_hit = 1'b1;
      SRC_DIVA: src_hit = (psc_q & MASK_A) == MASK_A;
      SRC_DIVB: src_hit = (psc_q & MASK_B) == MASK_B;
      default:  src_hit = alt_tick_i;
    endcase
  end

  assign tick_o = run_i & src_hit;

  // R4
  divided_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && src_i != SRC_DIV1 && src_i != SRC_ALT
     && $past(src_i) == src_i && $past(tick_o)) |-> !tick_o);

endmodule

// File: rtl/dct_shadow.sv
module dct_shadow #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         load_i,
  output logic [W-1:0] active_o
);

  logic [W-1:0] buf_q;
  logic [W-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_i) buf_q <= wdata_i;
      if (wr_i && !run_i) act_q <= wdata_i;
      else if (load_i)    act_q <= buf_q;
    end
  end

  assign active_o = act_q;

  // R8
  stopped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && wr_i) |=> active_o == $past(wdata_i));

  // R9
  running_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> active_o == $past(active_o));

endmodule

// File: rtl/dct_wave.sv
module dct_wave
  import dct_pkg::*;
#(
  parameter int unsigned N_OUT = 6,
  parameter int unsigned GRP   = 3,
  parameter int unsigned NG    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hit0_i,
  input  logic             hit1_i,
  input  lvl_act_e         act0_i,
  input  lvl_act_e         act1_i,
  input  logic [NG-1:0]    inv_i,
  input  logic [N_OUT-1:0] en_i,
  input  logic [N_OUT-1:0] port_i,
  output logic [N_OUT-1:0] wave_o
);

  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lvl_q <= 1'b0;
    else if (!run_i) lvl_q <= 1'b0;
    else if (hit1_i) lvl_q <= apply_act(act1_i, lvl_q);
    else if (hit0_i) lvl_q <= apply_act(act0_i, lvl_q);
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    assign wave_o[g] = port_i[g] & en_i[g] & (lvl_q ^ inv_i[g / GRP]);
  end

  // R10
  cmp1_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && hit0_i && hit1_i && act1_i == ACT_HIGH && act0_i == ACT_LOW) |=> lvl_q);

  // R10
  toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && hit0_i && !hit1_i && act0_i == ACT_TOGGLE) |=> lvl_q != $past(lvl_q));

  // R3
  stop_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !lvl_q);

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_OUT = 6,
  parameter int unsigned GRP   = 3,
  parameter int unsigned DIV_A = 8,
  parameter int unsigned DIV_B = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alt_tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [N_OUT-1:0]  port_data_i,
  output logic [N_OUT-1:0]  wave_o,
  output logic              irq_cmp0_o,
  output logic              irq_cmp1_o,
  output logic              irq_ovf_o
);

  localparam int unsigned NG    = (N_OUT + GRP - 1) / GRP;
  localparam int unsigned N_CMP = 2;

  ctrl_t             ctrl_q;
  logic [N_OUT-1:0]  oen_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cmp_act [N_CMP];
  logic [N_CMP-1:0]  hit;
  logic              tick;
  logic              ovf_hit;
  logic              wrap_clr;
  logic              load;
  logic [CTRL_W-1:0] ctrl_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      oen_q  <= '0;
    end else if (we_i) begin
      if (addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (addr_i == A_OEN)  oen_q  <= wdata_i[N_OUT-1:0];
    end
  end

  dct_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_psc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (ctrl_q.run),
    .src_i      (ctrl_q.src),
    .alt_tick_i (alt_tick_i),
    .tick_o     (tick)
  );

  assign ovf_hit  = tick & (&cnt_q);
  assign wrap_clr = ctrl_q.clr & hit[1];
  assign load     = ctrl_q.clr ? hit[1] : ovf_hit;

  for (genvar ch = 0; ch < N_CMP; ch++) begin : g_cmp
    logic wr;
    assign wr      = we_i && (addr_i == A_CMP0 + ADDR_W'(ch));
    assign hit[ch] = tick && (cnt_q == cmp_act[ch]);

    dct_shadow #(.W(CNT_W)) u_shadow (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (ctrl_q.run),
      .wr_i     (wr),
      .wdata_i  (wdata_i),
      .load_i   (load),
      .active_o (cmp_act[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!ctrl_q.run) cnt_q <= '0;
    else if (tick)        cnt_q <= wrap_clr ? '0 : cnt_q + CNT_W'(1);
  end

  assign irq_cmp0_o = hit[0];
  assign irq_cmp1_o = hit[1];
  assign irq_ovf_o  = ovf_hit;

  dct_wave #(.N_OUT(N_OUT), .GRP(GRP), .NG(NG)) u_wave (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctrl_q.run),
    .hit0_i (hit[0]),
    .hit1_i (hit[1]),
    .act0_i (ctrl_q.act0),
    .act1_i (ctrl_q.act1),
    .inv_i  (ctrl_q.inv[NG-1:0]),
    .en_i   (oen_q),
    .port_i (port_data_i),
    .wave_o (wave_o)
  );

  assign ctrl_bits = ctrl_q;

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = CNT_W'(ctrl_bits);
      A_OEN:   rdata_o = CNT_W'(oen_q);
      A_CMP0:  rdata_o = cmp_act[0];
      A_CMP1:  rdata_o = cmp_act[1];
      A_COUNT: rdata_o = cnt_q;
      default: rdata_o = '0;
    endcase
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.run && tick && !irq_ovf_o && !(ctrl_q.clr && irq_cmp1_o))
    |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.run && !tick) |=> cnt_q == $past(cnt_q));

  // R3
  stop_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.run |=> cnt_q == '0);

  // R6
  clr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_cmp1_o && ctrl_q.clr) |=> cnt_q == '0);

  // R7
  ovf_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ovf_o |=> cnt_q == '0);

endmodule

// File: tb/dual_cmp_timer_bench.sv
module dual_cmp_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alt_r = 1'b0;
  logic        we_r = 1'b0;
  logic [2:0]  addr_r = 3'd0;
  logic [15:0] wdata_r = 16'd0;
  logic [5:0]  port_r = 6'd0;
  logic [15:0] rdata;
  logic [5:0]  wave;
  logic        irq0, irq1, irqo;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  // model state
  logic [9:0]  m_ctrl = '0;
  logic [5:0]  m_oen = '0;
  logic [15:0] m_cnt = '0, m_act0 = '0, m_act1 = '0, m_buf0 = '0, m_buf1 = '0;
  logic [4:0]  m_psc = '0;
  logic        m_lvl = 1'b0;

  always #2.5 clk = ~clk;

  dual_cmp_timer u_dual_cmp_timer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .alt_tick_i  (alt_r),
    .we_i        (we_r),
    .addr_i      (addr_r),
    .wdata_i     (wdata_r),
    .rdata_o     (rdata),
    .port_data_i (port_r),
    .wave_o      (wave),
    .irq_cmp0_o  (irq0),
    .irq_cmp1_o  (irq1),
    .irq_ovf_o   (irqo)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic act_fn(input logic [1:0] a, input logic cur);
    case (a)
      2'd1:    return 1'b0;
      2'd2:    return 1'b1;
      2'd3:    return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic logic [5:0] wave_fn(input logic [5:0] port, input logic [5:0] en,
                                         input logic lvl, input logic [1:0] inv);
    logic [5:0] w;
    for (int i = 0; i < 6; i++) w[i] = port[i] & en[i] & (lvl ^ inv[i / 3]);
    return w;
  endfunction

  function automatic logic [15:0] read_fn(input logic [2:0] a);
    case (a)
      3'd0:    return {6'd0, m_ctrl};
      3'd1:    return {10'd0, m_oen};
      3'd2:    return m_act0;
      3'd3:    return m_act1;
      3'd4:    return m_cnt;
      default: return 16'd0;
    endcase
  endfunction

  task automatic cycle(input logic we, input logic [2:0] a, input logic [15:0] d);
    logic run, clr, st, tk, h0, h1, ov, ld;
    logic [1:0] src;
    logic [15:0] ob0, ob1;
    @(negedge clk);
    we_r = we; addr_r = a; wdata_r = d;
    port_r = 6'($urandom);
    alt_r = ($urandom % 3) == 0;
    #1;
    run = m_ctrl[0]; clr = m_ctrl[1]; src = m_ctrl[3:2];
    case (src)
      2'd0:    st = 1'b1;
      2'd1:    st = (m_psc[2:0] == 3'd7);
      2'd2:    st = (m_psc == 5'd31);
      default: st = alt_r;
    endcase
    tk = run & st;
    h0 = tk && (m_cnt == m_act0);
    h1 = tk && (m_cnt == m_act1);
    ov = tk && (m_cnt == 16'hFFFF);
    chk("R5 R9 irq_cmp0", 16'(irq0), 16'(h0));
    chk("R6 R9 irq_cmp1", 16'(irq1), 16'(h1));
    chk("R7 irq_ovf", 16'(irqo), 16'(ov));
    chk("R10 R11 wave", 16'(wave), 16'(wave_fn(port_r, m_oen, m_lvl, m_ctrl[9:8])));
    chk("R2 R4 R12 rdata", rdata, read_fn(a));
    // next state
    ld = clr ? h1 : ov;
    ob0 = m_buf0; ob1 = m_buf1;
    if (we && a == 3'd2) begin
      m_buf0 = d;
      if (!run) m_act0 = d; else if (ld) m_act0 = ob0;
    end else if (ld) m_act0 = ob0;
    if (we && a == 3'd3) begin
      m_buf1 = d;
      if (!run) m_act1 = d; else if (ld) m_act1 = ob1;
    end else if (ld) m_act1 = ob1;
    if (!run)    m_lvl = 1'b0;
    else if (h1) m_lvl = act_fn(m_ctrl[7:6], m_lvl);
    else if (h0) m_lvl = act_fn(m_ctrl[5:4], m_lvl);
    if (!run)    m_cnt = 16'd0;
    else if (tk) m_cnt = (clr && h1) ? 16'd0 : m_cnt + 16'd1;
    m_psc = run ? m_psc + 5'd1 : 5'd0;
    if (we && a == 3'd0) m_ctrl = d[9:0];
    if (we && a == 3'd1) m_oen = d[5:0];
  endtask

  task automatic session(input logic clr, input logic [1:0] src, input logic [1:0] a0,
                         input logic [1:0] a1, input logic [1:0] inv, input logic [5:0] oen,
                         input logic [15:0] c0, input logic [15:0] c1,
                         input int len, input int wprob, input int vmax);
    logic [15:0] ctl;
    ctl = {6'd0, inv, a1, a0, src, clr, 1'b0};
    cycle(1'b1, 3'd0, ctl);
    cycle(1'b1, 3'd2, c0);                  // R8 immediate while stopped
    cycle(1'b1, 3'd3, c1);
    cycle(1'b1, 3'd1, {10'd0, oen});
    cycle(1'b0, 3'd2, 16'd0);
    cycle(1'b0, 3'd3, 16'd0);
    cycle(1'b1, 3'd0, ctl | 16'd1);
    for (int i = 0; i < len; i++) begin
      if (($urandom % wprob) == 0) begin
        int pick;
        pick = 2 + int'($urandom % 3);   // addr 4 write must be ignored (R2)
        cycle(1'b1, 3'(pick), 16'($urandom % vmax));
      end else begin
        cycle(1'b0, 3'($urandom % 6), 16'd0);
      end
    end
    cycle(1'b1, 3'd0, ctl);                 // R3 stop
    for (int i = 0; i < 4; i++) cycle(1'b0, 3'd4, 16'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0D17));
    #0.5;
    rst_n = 1'b0;
    #12;
    // R1 reset state
    chk("R1 irq_cmp0", 16'(irq0), 16'd0);
    chk("R1 irq_cmp1", 16'(irq1), 16'd0);
    chk("R1 irq_ovf", 16'(irqo), 16'd0);
    chk("R1 wave", 16'(wave), 16'd0);
    for (int a = 0; a < 8; a++) begin
      addr_r = 3'(a);
      #0.2;
      chk("R1 rdata", rdata, 16'd0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R10 coincident matches, compare-1 action wins, clear mode
    session(1'b1, 2'd0, 2'd1, 2'd2, 2'b00, 6'h3F, 16'd5, 16'd5, 80, 1000000, 16);
    session(1'b1, 2'd0, 2'd2, 2'd1, 2'b10, 6'h3F, 16'd7, 16'd7, 80, 1000000, 16);
    // R4 each source with toggles
    session(1'b1, 2'd1, 2'd3, 2'd3, 2'b01, 6'h3F, 16'd2, 16'd6, 600, 1000000, 16);
    session(1'b1, 2'd2, 2'd3, 2'd0, 2'b11, 6'h2D, 16'd1, 16'd3, 900, 1000000, 16);
    session(1'b1, 2'd3, 2'd2, 2'd1, 2'b00, 6'h3F, 16'd4, 16'd9, 500, 1000000, 16);
    // R9 buffered writes in clear mode
    session(1'b1, 2'd0, 2'd3, 2'd1, 2'b00, 6'h3F, 16'd3, 16'd10, 1500, 7, 24);
    // random sessions
    for (int s = 0; s < 14; s++) begin
      logic cm;
      cm = 1'($urandom);
      session(cm, 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), 6'($urandom),
              16'($urandom % 40), 16'($urandom % 40), 1500, 11, cm ? 40 : 65536);
    end
    // R7 R9 free-run across overflow, buffered writes transfer at wrap
    session(1'b0, 2'd0, 2'd3, 2'd2, 2'b01, 6'h3F, 16'd100, 16'd40000, 70000, 3000, 65536);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 180000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule